// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Transfer Master

This block is a bus master for a shared bus on which one set of lines carries first an address and then data. A local requester hands it one command at a time: an operation code, a start address, a data word (the write value, or the XOR mask for an atomic update) and a beat count for bursts. The master runs the address phase and one or more data phases. It waits on the slave's transfer-acknowledge line for each data phase. It returns read data beat by beat, then gives a one-cycle completion pulse and a compare flag.

The controller is a single state machine. Its states are `ST_IDLE`, `ST_ADDR`, `ST_RD_DATA`, `ST_WR_DATA`, `ST_MOD_WR`, `ST_CHK_RD` and `ST_DONE`. The transitions are:
- `ST_IDLE`→`ST_ADDR` when a command is accepted.
- `ST_ADDR`→`ST_WR_DATA` for a write or a verified write; `ST_ADDR`→`ST_RD_DATA` for every other operation.
- `ST_RD_DATA`, on acknowledge: →`ST_MOD_WR` for an atomic update; →`ST_RD_DATA` again for a burst that has beats left; →`ST_DONE` otherwise.
- `ST_WR_DATA`, on acknowledge: →`ST_CHK_RD` for a verified write; →`ST_DONE` otherwise.
- `ST_MOD_WR`→`ST_DONE` and `ST_CHK_RD`→`ST_DONE`, each on acknowledge.
- `ST_DONE`→`ST_IDLE` unconditionally.

Without an acknowledge, every data state holds.

Top module: `mbus_master`

## Requirements
- R1: After reset `cmd_ready` is 1, and `bus_ale`, `bus_mrd`, `bus_mwr`, `bus_ad_oe`, `bus_lock`, `bus_incr`, `done` and `rd_valid` are all 0.
- R2: Each command has exactly one address phase. It is one cycle with `bus_ale`=1, `bus_ad_oe`=1 and `bus_ad_out` equal to the command address, and the first data phase follows immediately.
- R3: In a read data phase `bus_mrd`=1 and `bus_ad_oe`=0. The value on `bus_ad_in` in the acknowledge cycle appears on `rd_data`, with a one-cycle `rd_valid`, in the next cycle.
- R4: In a write data phase `bus_mwr`=1, `bus_ad_oe`=1 and `bus_ad_out` carries the data, held stable until acknowledge.
- R5: A data phase lasts until `bus_ack`. With a slave that acknowledges after W wait cycles and a command of P data phases, `done` is seen 2+P·(W+1) cycles after the accepting edge.
- R6: Atomic update (op 2): a read, then immediately a write of (read value XOR `cmd_wdata`) to the same address, with no address phase between them. `bus_lock` is 1 from the address phase through the write phase and 0 in all other operations.
- R7: Verified write (op 3): a write of `cmd_wdata`, then immediately a read of the same address. `mismatch` is 1 with `done` exactly when the returned value differs from the written one.
- R8: Burst read (op 4): `cmd_len` read beats, with `cmd_len`=0 meaning one beat. `bus_incr`=1 in every beat tells the slave to advance to the next address, and each beat gives an `rd_valid` pulse.
- R9: Op codes are 0 read, 1 write, 2 atomic update, 3 verified write and 4 burst read. Codes 5 to 7 run as a single read.
- R10: A command is taken only when `cmd_ready`=1, which holds only while idle. `cmd_valid` while busy has no effect, and `done` is a single-cycle pulse.
- R11: `bus_mrd` and `bus_mwr` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Master idle, command will be taken |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | WIDTH | Start address |
| cmd_wdata | input | WIDTH | Write data or XOR mask |
| cmd_len | input | LEN_W | Burst beat count |
| rd_data | output | WIDTH | Returned read data |
| rd_valid | output | 1 | One-cycle strobe per read beat |
| done | output | 1 | One-cycle completion pulse |
| mismatch | output | 1 | Verified-write compare failed |
| bus_ad_out | output | WIDTH | Shared lines, driven value |
| bus_ad_oe | output | 1 | Output enable for the shared lines |
| bus_ad_in | input | WIDTH | Shared lines, sampled value |
| bus_ale | output | 1 | Address phase strobe |
| bus_mrd | output | 1 | Memory read control line |
| bus_mwr | output | 1 | Memory write control line |
| bus_incr | output | 1 | Slave advances address after this beat |
| bus_lock | output | 1 | Atomic sequence in progress |
| bus_ack | input | 1 | Slave transfer acknowledge |

## Verification
All eight op codes are swept against a slave that inserts 0, 1 and 2 wait cycles. Burst lengths of 0, 1, 2, 4 and 5 are used, and one burst wraps the slave's address space. The completion cycle count separates a wait-state bug from a phase-sequencing bug. Read-back of the whole memory shows whether writes landed at the right address with the right value. A verified write against a slave that flips one bit on the way back shows the compare is live. A command held on the input during a busy read shows that the busy master ignores it.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_RMW   = 3'd2,
        OP_RAW   = 3'd3,
        OP_BLOCK = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RD_DATA,
        ST_WR_DATA,
        ST_MOD_WR,
        ST_CHK_RD,
        ST_DONE
    } state_e;

    // undefined codes fall back to a single read
    function automatic op_e decode_op(input logic [2:0] code);
        case (code)
            3'd1:    return OP_WRITE;
            3'd2:    return OP_RMW;
            3'd3:    return OP_RAW;
            3'd4:    return OP_BLOCK;
            default: return OP_READ;
        endcase
    endfunction

endpackage

// File: rtl/mbus_fsm.sv
module mbus_fsm
    import mbus_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cmd_valid,
    input  op_e    op_q,
    input  logic   bus_ack,
    input  logic   last_beat,
    output state_e state,
    output logic   accept,
    output logic   cmd_ready,
    output logic   ale,
    output logic   oe,
    output logic   mrd,
    output logic   mwr,
    output logic   incr,
    output logic   lock,
    output logic   done
);

    state_e state_nx;

    assign accept = cmd_valid && (state == ST_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (accept) state_nx = ST_ADDR;
            ST_ADDR:    state_nx = (op_q == OP_WRITE || op_q == OP_RAW) ? ST_WR_DATA : ST_RD_DATA;
            ST_RD_DATA: if (bus_ack) begin
                            if (op_q == OP_RMW)                     state_nx = ST_MOD_WR;
                            else if (op_q == OP_BLOCK && !last_beat) state_nx = ST_RD_DATA;
                            else                                     state_nx = ST_DONE;
                        end
            ST_WR_DATA: if (bus_ack) state_nx = (op_q == OP_RAW) ? ST_CHK_RD : ST_DONE;
            ST_MOD_WR:  if (bus_ack) state_nx = ST_DONE;
            ST_CHK_RD:  if (bus_ack) state_nx = ST_DONE;
            ST_DONE:    state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_ready = 1'b0;
        ale       = 1'b0;
        oe        = 1'b0;
        mrd       = 1'b0;
        mwr       = 1'b0;
        incr      = 1'b0;
        lock      = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE:    cmd_ready = 1'b1;
            ST_ADDR:    begin
                            ale  = 1'b1;
                            oe   = 1'b1;
                            lock = (op_q == OP_RMW);
                        end
            ST_RD_DATA: begin
                            mrd  = 1'b1;
                            incr = (op_q == OP_BLOCK);
                            lock = (op_q == OP_RMW);
                        end
            ST_WR_DATA: begin
                            mwr = 1'b1;
                            oe  = 1'b1;
                        end
            ST_MOD_WR:  begin
                            mwr  = 1'b1;
                            oe   = 1'b1;
                            lock = 1'b1;
                        end
            ST_CHK_RD:  mrd  = 1'b1;
            ST_DONE:    done = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/mbus_beat_ctr.sv
module mbus_beat_ctr #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic             beat,
    output logic             last_beat
);

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    logic [LEN_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       left_q <= ONE;
        else if (load)    left_q <= (len == '0) ? ONE : len;
        else if (beat && left_q != ONE) left_q <= left_q - ONE;
    end

    assign last_beat = (left_q == ONE);

endmodule

// File: rtl/mbus_datapath.sv
module mbus_datapath
    import mbus_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  state_e           state,
    input  logic [2:0]       cmd_op,
    input  logic [WIDTH-1:0] cmd_addr,
    input  logic [WIDTH-1:0] cmd_wdata,
    input  logic [WIDTH-1:0] bus_ad_in,
    input  logic             bus_ack,
    output op_e              op_q,
    output logic [WIDTH-1:0] ad_out,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             mismatch
);

    logic [WIDTH-1:0] addr_q;
    logic [WIDTH-1:0] wdata_q;
    logic [WIDTH-1:0] rd_q;
    logic             rdv_q;
    logic             mism_q;
    logic             rd_strobe;

    assign rd_strobe = bus_ack && (state == ST_RD_DATA || state == ST_CHK_RD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_READ;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            op_q    <= decode_op(cmd_op);
            addr_q  <= cmd_addr;
            wdata_q <= cmd_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= '0;
            rdv_q  <= 1'b0;
            mism_q <= 1'b0;
        end else begin
            rdv_q <= rd_strobe;
            if (rd_strobe) rd_q <= bus_ad_in;
            if (accept)
                mism_q <= 1'b0;
            else if (bus_ack && state == ST_CHK_RD)
                mism_q <= (bus_ad_in != wdata_q);
        end
    end

    // value placed on the shared lines
    always_comb begin
        unique case (state)
            ST_ADDR:    ad_out = addr_q;
            ST_WR_DATA: ad_out = wdata_q;
            ST_MOD_WR:  ad_out = rd_q ^ wdata_q;
            default:    ad_out = '0;
        endcase
    end

    assign rd_data  = rd_q;
    assign rd_valid = rdv_q;
    assign mismatch = mism_q;

endmodule

// File: rtl/mbus_master.sv
module mbus_master
    import mbus_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [2:0]       cmd_op,
    input  logic [WIDTH-1:0] cmd_addr,
    input  logic [WIDTH-1:0] cmd_wdata,
    input  logic [LEN_W-1:0] cmd_len,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             done,
    output logic             mismatch,
    output logic [WIDTH-1:0] bus_ad_out,
    output logic             bus_ad_oe,
    input  logic [WIDTH-1:0] bus_ad_in,
    output logic             bus_ale,
    output logic             bus_mrd,
    output logic             bus_mwr,
    output logic             bus_incr,
    output logic             bus_lock,
    input  logic             bus_ack
);

    state_e state;
    op_e    op_q;
    logic   accept;
    logic   last_beat;
    logic   beat;

    assign beat = bus_ack && (state == ST_RD_DATA);

    mbus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .op_q      (op_q),
        .bus_ack   (bus_ack),
        .last_beat (last_beat),
        .state     (state),
        .accept    (accept),
        .cmd_ready (cmd_ready),
        .ale       (bus_ale),
        .oe        (bus_ad_oe),
        .mrd       (bus_mrd),
        .mwr       (bus_mwr),
        .incr      (bus_incr),
        .lock      (bus_lock),
        .done      (done)
    );

    mbus_beat_ctr #(.LEN_W(LEN_W)) u_beats (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .len       (cmd_len),
        .beat      (beat),
        .last_beat (last_beat)
    );

    mbus_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .state     (state),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .bus_ad_in (bus_ad_in),
        .bus_ack   (bus_ack),
        .op_q      (op_q),
        .ad_out    (bus_ad_out),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .mismatch  (mismatch)
    );

endmodule

// File: rtl/mbus_master_chk.sv
module mbus_master_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_ready,
    input logic             done,
    input logic [WIDTH-1:0] bus_ad_out,
    input logic             bus_ad_oe,
    input logic             bus_ale,
    input logic             bus_mrd,
    input logic             bus_mwr,
    input logic             bus_lock,
    input logic             bus_ack
);

    a_r11_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_mrd && bus_mwr));

    a_r3_read_releases: assert property (@(posedge clk) disable iff (!rst_n)
        bus_mrd |-> !bus_ad_oe);

    a_r4_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
        bus_mwr |-> bus_ad_oe);

    a_r5_read_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_mrd && !bus_ack) |=> bus_mrd);

    a_r4_write_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_mwr && !bus_ack) |=> (bus_mwr && $stable(bus_ad_out)));

    a_r2_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> (!bus_ale && (bus_mrd || bus_mwr)));

    a_r6_lock_to_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_lock && bus_mrd && bus_ack) |=> (bus_mwr && bus_lock && !bus_ale));

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ale || bus_mrd || bus_mwr) |-> !cmd_ready);

endmodule

bind mbus_master mbus_master_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_ready  (cmd_ready),
    .done       (done),
    .bus_ad_out (bus_ad_out),
    .bus_ad_oe  (bus_ad_oe),
    .bus_ale    (bus_ale),
    .bus_mrd    (bus_mrd),
    .bus_mwr    (bus_mwr),
    .bus_lock   (bus_lock),
    .bus_ack    (bus_ack)
);

// File: tb/mbus_master_test.sv
module mbus_master_test;

    localparam int W  = 8;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [2:0]    cmd_op = '0;
    logic [W-1:0]  cmd_addr = '0;
    logic [W-1:0]  cmd_wdata = '0;
    logic [LW-1:0] cmd_len = '0;
    logic [W-1:0]  rd_data;
    logic          rd_valid, done, mismatch;
    logic [W-1:0]  bus_ad_out;
    logic          bus_ad_oe;
    logic [W-1:0]  bus_ad_in;
    logic          bus_ale, bus_mrd, bus_mwr, bus_incr, bus_lock, bus_ack;

    always #10 clk = ~clk;

    mbus_master #(.WIDTH(W), .LEN_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_len(cmd_len),
        .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .mismatch(mismatch),
        .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
        .bus_ale(bus_ale), .bus_mrd(bus_mrd), .bus_mwr(bus_mwr), .bus_incr(bus_incr),
        .bus_lock(bus_lock), .bus_ack(bus_ack)
    );

    // slave memory model: 16 words, address latched on bus_ale
    logic [W-1:0] mem [16];
    logic [3:0]   s_addr = '0;
    int           s_cnt = 0;
    int           wait_n = 0;
    logic [W-1:0] corrupt = '0;

    assign bus_ack   = (bus_mrd || bus_mwr) && (s_cnt == wait_n);
    assign bus_ad_in = bus_mrd ? (mem[s_addr] ^ corrupt) : '0;

    always @(posedge clk) begin
        if (bus_ale) s_addr <= bus_ad_out[3:0];
        if (bus_ack) begin
            s_cnt <= 0;
            if (bus_mwr) mem[s_addr] <= bus_ad_out;
            if (bus_incr) s_addr <= s_addr + 4'd1;
        end else if (bus_mrd || bus_mwr) begin
            s_cnt <= s_cnt + 1;
        end
    end

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] exp_mem [16];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run(input int op, input int addr, input int wd, input int len,
                       input int w, input bit hold, input bit corr);
        int a      = addr & 15;
        int op_eff = (op > 4) ? 0 : op;
        int beats  = (op_eff == 4) ? ((len == 0) ? 1 : len) : 1;
        int phases = (op_eff == 2 || op_eff == 3) ? 2 : beats;
        logic [W-1:0] old = exp_mem[a];
        logic [W-1:0] got [16];
        int nv = 0, lat = 0, ale_n = 0, bad_addr = 0, oe_bad = 0, both = 0;
        int lock_bad = 0, wr_n = 0, rd_n = 0, incr_n = 0, first_wr = -1;
        int wr_val = 0, extra_ale = 0;
        bit mism = 0, seen_done = 0;

        @(negedge clk);
        wait_n    = w;
        corrupt   = corr ? W'(1) : '0;
        cmd_op    = 3'(op);
        cmd_addr  = W'(addr);
        cmd_wdata = W'(wd);
        cmd_len   = LW'(len);
        cmd_valid = 1'b1;
        @(posedge clk);
        #1;
        if (hold) begin
            cmd_op    = 3'd1;
            cmd_wdata = 8'hEE;
        end else begin
            cmd_valid = 1'b0;
        end
        while (!seen_done && lat < 200) begin
            @(negedge clk);
            lat++;
            if (bus_ale) begin
                ale_n++;
                if (bus_ad_out != W'(addr)) bad_addr++;
            end
            if (bus_mrd && bus_mwr) both++;
            if ((bus_mrd && bus_ad_oe) || (bus_mwr && !bus_ad_oe)) oe_bad++;
            if (bus_ale || bus_mrd || bus_mwr) begin
                if ((op_eff == 2) != bus_lock) lock_bad++;
            end else if (bus_lock) lock_bad++;
            if (bus_ack && bus_mwr) begin
                wr_n++;
                wr_val = int'(bus_ad_out);
                if (first_wr < 0) first_wr = 1;
            end
            if (bus_ack && bus_mrd) begin
                rd_n++;
                if (bus_incr) incr_n++;
                if (first_wr < 0) first_wr = 0;
            end
            if (rd_valid && nv < 16) begin
                got[nv] = rd_data;
                nv++;
            end
            if (done) begin
                seen_done = 1;
                mism      = mismatch;
                cmd_valid = 1'b0;
            end
        end
        chk(seen_done, "R10 done reached", lat, 2 + phases * (w + 1));
        chk(lat == 2 + phases * (w + 1), "R5 latency", lat, 2 + phases * (w + 1));
        chk(ale_n == 1 && bad_addr == 0, "R2 single address phase", ale_n, 1);
        chk(oe_bad == 0, "R3/R4 output enable", oe_bad, 0);
        chk(both == 0, "R11 strobes exclusive", both, 0);
        chk(lock_bad == 0, "R6 lock line", lock_bad, 0);
        unique case (op_eff)
            0: begin
                chk(nv == 1 && got[0] == old, "R3/R9 read data", int'(got[0]), int'(old));
                chk(wr_n == 0 && rd_n == 1, hold ? "R10 busy command ignored" : "R9 read only",
                    wr_n, 0);
            end
            1: begin
                chk(wr_n == 1 && rd_n == 0 && wr_val == wd, "R4 write value", wr_val, wd);
                exp_mem[a] = W'(wd);
            end
            2: begin
                chk(nv == 1 && got[0] == old, "R6 old value returned", int'(got[0]), int'(old));
                chk(first_wr == 0 && wr_n == 1 && wr_val == int'(old ^ W'(wd)),
                    "R6 modified write", wr_val, int'(old ^ W'(wd)));
                exp_mem[a] = old ^ W'(wd);
            end
            3: begin
                chk(first_wr == 1 && wr_n == 1 && rd_n == 1 && wr_val == wd,
                    "R7 write then read", wr_val, wd);
                chk(nv == 1 && got[0] == (W'(wd) ^ corrupt), "R7 read back",
                    int'(got[0]), int'(W'(wd) ^ corrupt));
                chk(mism == corr, "R7 mismatch flag", int'(mism), int'(corr));
                exp_mem[a] = W'(wd);
            end
            default: begin
                chk(nv == beats && incr_n == beats, "R8 beat count", nv, beats);
                for (int k = 0; k < beats; k++)
                    chk(got[k] == exp_mem[(a + k) & 15], "R8 burst data",
                        int'(got[k]), int'(exp_mem[(a + k) & 15]));
            end
        endcase
        // idle afterwards, even if a command was held on the input
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (bus_ale || !cmd_ready || done) extra_ale++;
        end
        chk(extra_ale == 0, "R10 idle after done", extra_ale, 0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem[i]     = W'(i * 29 + 3);
            exp_mem[i] = W'(i * 29 + 3);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(cmd_ready && !bus_ale && !bus_mrd && !bus_mwr && !bus_ad_oe && !bus_lock
            && !bus_incr && !done && !rd_valid, "R1 reset state", int'(cmd_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready && !bus_ale && !done, "R1 idle after reset", int'(cmd_ready), 1);

        for (int w = 0; w < 3; w++)
            for (int op = 0; op < 8; op++)
                run(op, (op * 3 + w * 5) & 15, (op * 41 + w * 17 + 9) & 255, w * 2, w, 0, 0);
        run(4, 6, 0, 1, 1, 0, 0);
        run(4, 14, 0, 5, 0, 0, 0);
        run(0, 7, 0, 0, 2, 1, 0);
        run(3, 9, 8'h5A, 0, 1, 0, 1);
        run(2, 9, 8'hFF, 0, 0, 0, 0);
        run(4, 0, 0, 8, 0, 0, 0);
        run(4, 8, 0, 8, 1, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule